// File: doc/BRIEF.md
# Instruction issue and skip sequencer

This block sits between program memory and the execute stage of a small processor with 24-bit instruction words. Every cycle it presents a program address on `pc`, takes the word that memory returns for that address in the same cycle, and decides what the execute stage receives. The execute stage gets either a real instruction (`issue_valid`) or a forced all-zero NOP (`bubble`). The block spreads double-word instructions over two cycles. After a taken conditional skip it swallows the following instruction, whether that instruction is one word or two. After a branch or a return it inserts flush cycles while the new address takes effect.

The top 8 bits of a word are its opcode. A local opcode table assigns each opcode to one of these classes: plain single word (0x10 to 0x1F), double word (0x20), conditional skip (0x30), branch (0x40), conditional branch (0x41), return (0x50), and NOP (0x00). The NOP class also covers an extension word that is reached on its own. Every other opcode is unknown. The execute stage drives `cond_true` in the same cycle that a skip or conditional branch issues. A return stack outside the block supplies `ret_addr`.

The sequencer is a state machine with these states:
- `ST_ISSUE`: normal issue.
- `ST_SECOND`: issues the second word of a double-word instruction.
- `ST_SKIP1` and `ST_SKIP2`: bubbles that replace a skipped one- or two-word instruction.
- `ST_FLUSH2` and `ST_FLUSH1`: bubbles after a redirect, with the address held.

The transitions are:
- `ST_ISSUE` goes to `ST_SECOND` on a double word.
- `ST_ISSUE` goes to `ST_SKIP1` on a taken skip.
- `ST_ISSUE` goes to `ST_FLUSH1` on a taken branch.
- `ST_ISSUE` goes to `ST_FLUSH2` on a return.
- `ST_ISSUE` otherwise stays in `ST_ISSUE`.
- `ST_SKIP1` goes to `ST_SKIP2` if the skipped word is a double-word opcode, and otherwise to `ST_ISSUE`.
- `ST_FLUSH2` goes to `ST_FLUSH1`.
- `ST_SECOND`, `ST_SKIP2` and `ST_FLUSH1` go to `ST_ISSUE`.

Top module: `issue_seq`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `pc` becomes 0 and any pending second-word, skip or flush state is dropped. While `rst` is high, `issue_valid`, `bubble` and `exec_word` are 0. The first cycle after reset issues the word at address 0.
- R2: Out of reset, exactly one of `issue_valid` and `bubble` is high in every cycle. In a bubble cycle `exec_word` is 24'h000000.
- R3: An opcode in 0x10..0x1F takes one cycle. `exec_word` equals the fetched word, and `pc` then advances by 2.
- R4: Opcode 0x20 takes two issue cycles. The first cycle passes the first word and the second passes the next word unchanged, whatever its content. `pc` advances by 2 after each.
- R5: A word with opcode 0x00 that is not the second half of a double-word instruction issues as a NOP. `issue_valid` is 1, `exec_word` is 0, and `pc` advances by 2.
- R6: An opcode outside the table issues for one cycle as a NOP. `exec_word` is 0 and `pc` advances by 2.
- R7: Opcode 0x30 passes its word and advances `pc` by 2. If `cond_true` is high in its issue cycle, the next instruction is replaced by bubbles while `pc` keeps advancing by 2 per cycle. There is one bubble if that instruction's opcode is not 0x20 and two if it is. If `cond_true` is low, the skip has no further effect.
- R8: Opcode 0x40 passes its word and loads `pc` with bits 15:0 of the word. One bubble follows, during which `pc` holds the target.
- R9: Opcode 0x41 behaves as R8 when `cond_true` is high in its issue cycle, and as R3 otherwise.
- R10: Opcode 0x50 passes its word and loads `pc` from `ret_addr`. Two bubbles follow, during which `pc` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_data | input | WORD_W | Program word read at address `pc`, same cycle |
| cond_true | input | 1 | Outcome of the test of the skip or conditional branch issuing this cycle |
| ret_addr | input | PC_W | Return target from the external stack |
| pc | output | PC_W | Program address of the current cycle |
| issue_valid | output | 1 | A real instruction cycle is presented |
| bubble | output | 1 | A forced NOP cycle is presented |
| exec_word | output | WORD_W | Word given to execute, zero for a NOP or bubble |

## Verification
The main stimulus is a random program that mixes every opcode class. The program includes extension words with non-zero low bits, skips landing on double-word instructions, and back-to-back redirects. The bench toggles `cond_true` randomly on every cycle. This tells apart a skip over one word from a skip over two, a taken conditional branch from a fall-through, and an extension word consumed with its first half from a lone one that must become a NOP. A directed sequence applies reset while a return's flush is pending, which shows whether the pending bubbles are dropped.

// File: rtl/issue_pkg.sv
package issue_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OP_NOP     = 8'h00;
    localparam logic [OPC_W-1:0] OP_ALU_LO  = 8'h10;
    localparam logic [OPC_W-1:0] OP_ALU_HI  = 8'h1F;
    localparam logic [OPC_W-1:0] OP_DOUBLE  = 8'h20;
    localparam logic [OPC_W-1:0] OP_SKIP    = 8'h30;
    localparam logic [OPC_W-1:0] OP_BRANCH  = 8'h40;
    localparam logic [OPC_W-1:0] OP_CBRANCH = 8'h41;
    localparam logic [OPC_W-1:0] OP_RETURN  = 8'h50;

    typedef enum logic [2:0] {
        C_NOP, C_SINGLE, C_DOUBLE, C_SKIP,
        C_BRANCH, C_CBRANCH, C_RETURN, C_UNKNOWN
    } op_class_t;

    typedef enum logic [2:0] {
        ST_ISSUE, ST_SECOND, ST_SKIP1, ST_SKIP2, ST_FLUSH2, ST_FLUSH1
    } seq_state_t;

    typedef enum logic [1:0] {
        PC_HOLD, PC_STEP, PC_LOAD
    } pc_op_t;

endpackage

// File: rtl/issue_decode.sv
module issue_decode
    import issue_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_class_t        cls
);
    always_comb begin
        if (opcode >= OP_ALU_LO && opcode <= OP_ALU_HI) begin
            cls = C_SINGLE;
        end else begin
            unique case (opcode)
                OP_NOP:     cls = C_NOP;
                OP_DOUBLE:  cls = C_DOUBLE;
                OP_SKIP:    cls = C_SKIP;
                OP_BRANCH:  cls = C_BRANCH;
                OP_CBRANCH: cls = C_CBRANCH;
                OP_RETURN:  cls = C_RETURN;
                default:    cls = C_UNKNOWN;
            endcase
        end
    end
endmodule

// File: rtl/issue_pc.sv
module issue_pc
    import issue_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  pc_op_t          op,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            unique case (op)
                PC_STEP: pc <= pc + STEP;
                PC_LOAD: pc <= target;
                default: pc <= pc;
            endcase
        end
    end
endmodule

// File: rtl/issue_fsm.sv
module issue_fsm
    import issue_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  op_class_t cls,
    input  logic      cond_true,
    output pc_op_t    pc_op,
    output logic      use_ret,
    output logic      issue_valid,
    output logic      bubble,
    output logic      pass_word
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ISSUE;
        else     state <= nxt;
    end

    always_comb begin
        nxt     = ST_ISSUE;
        pc_op   = PC_STEP;
        use_ret = 1'b0;
        unique case (state)
            ST_ISSUE: begin
                unique case (cls)
                    C_DOUBLE: nxt = ST_SECOND;
                    C_SKIP:   nxt = cond_true ? ST_SKIP1 : ST_ISSUE;
                    C_BRANCH: begin
                        pc_op = PC_LOAD;
                        nxt   = ST_FLUSH1;
                    end
                    C_CBRANCH: begin
                        if (cond_true) begin
                            pc_op = PC_LOAD;
                            nxt   = ST_FLUSH1;
                        end
                    end
                    C_RETURN: begin
                        pc_op   = PC_LOAD;
                        use_ret = 1'b1;
                        nxt     = ST_FLUSH2;
                    end
                    default: nxt = ST_ISSUE;
                endcase
            end
            ST_SECOND: nxt = ST_ISSUE;
            ST_SKIP1:  nxt = (cls == C_DOUBLE) ? ST_SKIP2 : ST_ISSUE;
            ST_SKIP2:  nxt = ST_ISSUE;
            ST_FLUSH2: begin
                pc_op = PC_HOLD;
                nxt   = ST_FLUSH1;
            end
            ST_FLUSH1: begin
                pc_op = PC_HOLD;
                nxt   = ST_ISSUE;
            end
            default: nxt = ST_ISSUE;
        endcase
    end

    always_comb begin
        issue_valid = 1'b0;
        bubble      = 1'b0;
        pass_word   = 1'b0;
        if (!rst) begin
            unique case (state)
                ST_ISSUE: begin
                    issue_valid = 1'b1;
                    pass_word   = (cls != C_NOP) && (cls != C_UNKNOWN);
                end
                ST_SECOND: begin
                    issue_valid = 1'b1;
                    pass_word   = 1'b1;
                end
                default: bubble = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/issue_seq.sv
module issue_seq
    import issue_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int PC_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] imem_data,
    input  logic              cond_true,
    input  logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   pc,
    output logic              issue_valid,
    output logic              bubble,
    output logic [WORD_W-1:0] exec_word
);
    op_class_t       cls;
    pc_op_t          pc_op;
    logic            use_ret;
    logic            pass_word;
    logic [PC_W-1:0] target;

    issue_decode u_dec (
        .opcode (imem_data[WORD_W-1 -: OPC_W]),
        .cls    (cls)
    );

    issue_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .cond_true   (cond_true),
        .pc_op       (pc_op),
        .use_ret     (use_ret),
        .issue_valid (issue_valid),
        .bubble      (bubble),
        .pass_word   (pass_word)
    );

    assign target = use_ret ? ret_addr : imem_data[PC_W-1:0];

    issue_pc #(.PC_W(PC_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .op     (pc_op),
        .target (target),
        .pc     (pc)
    );

    assign exec_word = pass_word ? imem_data : '0;
endmodule

// File: rtl/issue_seq_chk.sv
module issue_seq_chk
    import issue_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int PC_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cond_true,
    input logic [PC_W-1:0]   ret_addr,
    input logic [PC_W-1:0]   pc,
    input logic              issue_valid,
    input logic              bubble,
    input logic [WORD_W-1:0] exec_word
);
    logic [OPC_W-1:0] op;
    assign op = exec_word[WORD_W-1 -: OPC_W];

    // R1
    reset_pc_zero_chk: assert property (@(posedge clk)
        rst |=> (pc == '0));

    // R2
    one_kind_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({issue_valid, bubble}));

    // R2
    bubble_is_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bubble |-> (exec_word == '0));

    // R3
    single_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op >= OP_ALU_LO && op <= OP_ALU_HI) |=>
            ((pc - $past(pc)) == PC_W'(2)));

    // R4
    double_second_issues_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op == OP_DOUBLE) |=> (issue_valid && (pc - $past(pc)) == PC_W'(2)));

    // R7
    skip_taken_bubbles_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op == OP_SKIP && cond_true) |=> bubble);

    // R8
    branch_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op == OP_BRANCH) |=> (bubble && pc == $past(exec_word[PC_W-1:0])));

    // R10
    return_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op == OP_RETURN) |=> (bubble && pc == $past(ret_addr)));
endmodule

bind issue_seq issue_seq_chk #(.WORD_W(WORD_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/test_issue_seq.sv
module test_issue_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 24;
    localparam int PC_W = 16;
    localparam int N_RANDOM = 4000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORD_W-1:0] imem_data;
    logic              cond_true = 1'b0;
    logic [PC_W-1:0]   ret_addr = '0;
    logic [PC_W-1:0]   pc;
    logic              issue_valid;
    logic              bubble;
    logic [WORD_W-1:0] exec_word;

    logic [WORD_W-1:0] mem [256];

    int total = 0;
    int bad = 0;

    // bench model state
    logic [PC_W-1:0] m_pc = '0;
    int              m_flush = 0;
    string           m_flush_tag = "R8";
    bit              m_second = 0;
    bit              m_skip = 0;
    bit              m_skip2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_data = mem[int'(pc[8:1])];

    issue_seq #(.WORD_W(WORD_W), .PC_W(PC_W)) i_issue_seq (
        .clk(clk), .rst(rst), .imem_data(imem_data), .cond_true(cond_true),
        .ret_addr(ret_addr), .pc(pc), .issue_valid(issue_valid),
        .bubble(bubble), .exec_word(exec_word)
    );

    function automatic logic [PC_W-1:0] rand_addr();
        return PC_W'(($urandom % 256) * 2);
    endfunction

    function automatic bit is_known(input logic [7:0] op);
        return (op >= 8'h10 && op <= 8'h1F) || op == 8'h20 || op == 8'h30 ||
               op == 8'h40 || op == 8'h41 || op == 8'h50;
    endfunction

    task automatic check(input string tag, input logic [PC_W+WORD_W+1:0] got,
                         input logic [PC_W+WORD_W+1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s pc/valid/bubble/word got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one cycle: drive inputs at negedge, check outputs, advance model
    task automatic cycle(input bit r);
        logic [WORD_W-1:0] w;
        logic [7:0]        op;
        logic [PC_W-1:0]   e_pc;
        logic              e_v, e_b;
        logic [WORD_W-1:0] e_w;
        string             tag;
        @(negedge clk);
        rst = r;
        cond_true = 1'($urandom % 2);
        ret_addr = rand_addr();
        #1;
        w = mem[int'(m_pc[8:1])];
        op = w[23:16];
        e_pc = m_pc; e_v = 1'b0; e_b = 1'b0; e_w = '0; tag = "R1";
        if (r) begin
            m_flush = 0; m_second = 0; m_skip = 0; m_skip2 = 0; m_pc = '0;
        end else if (m_flush > 0) begin
            e_b = 1'b1; tag = m_flush_tag; m_flush--;
        end else if (m_skip2) begin
            e_b = 1'b1; tag = "R7"; m_skip2 = 0; m_pc = m_pc + 2;
        end else if (m_skip) begin
            e_b = 1'b1; tag = "R7"; m_skip = 0; m_skip2 = (op == 8'h20); m_pc = m_pc + 2;
        end else if (m_second) begin
            e_v = 1'b1; e_w = w; tag = "R4"; m_second = 0; m_pc = m_pc + 2;
        end else begin
            e_v = 1'b1;
            e_w = is_known(op) ? w : '0;
            m_pc = m_pc + 2;
            if (op == 8'h00) tag = "R5";
            else if (!is_known(op)) tag = "R6";
            else if (op == 8'h20) begin tag = "R4"; m_second = 1; end
            else if (op == 8'h30) begin tag = "R7"; m_skip = cond_true; end
            else if (op == 8'h40 || (op == 8'h41 && cond_true)) begin
                tag = (op == 8'h40) ? "R8" : "R9";
                m_pc = w[PC_W-1:0]; m_flush = 1; m_flush_tag = tag;
            end else if (op == 8'h41) tag = "R9";
            else if (op == 8'h50) begin
                tag = "R10"; m_pc = ret_addr; m_flush = 2; m_flush_tag = "R10";
            end else tag = "R3";
        end
        check(tag, {pc, issue_valid, bubble, exec_word}, {e_pc, e_v, e_b, e_w});
        if (!r) check("R2", {30'd0, issue_valid ^ bubble}, 32'd1);
    endtask

    task automatic fill_random();
        int i = 0;
        while (i < 256) begin
            int k = int'($urandom % 16);
            logic [15:0] lo = 16'($urandom);
            if (k < 5)       mem[i] = {8'h10 + 8'($urandom % 16), lo};
            else if (k < 7)  mem[i] = {8'h20, lo};
            else if (k < 9)  mem[i] = {8'h30, lo};
            else if (k == 9) mem[i] = {8'h40, rand_addr()};
            else if (k == 10) mem[i] = {8'h41, rand_addr()};
            else if (k == 11) mem[i] = {8'h50, lo};
            else if (k == 12) mem[i] = {8'h00, lo};
            else             mem[i] = {8'hE0 + 8'($urandom % 16), lo};
            if (k >= 5 && k < 7 && i < 255) begin
                i++;
                mem[i] = {8'h00, 16'($urandom)};
            end
            i++;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        fill_random();
        // directed corners at the start: taken skip over a double word
        mem[0] = {8'h30, 16'h0};
        mem[1] = {8'h20, 16'h1234};
        mem[2] = {8'h00, 16'hBEEF};
        mem[3] = {8'h11, 16'h0};
        repeat (2) cycle(1'b1);
        for (int n = 0; n < N_RANDOM; n++) cycle(1'b0);
        // reset during a pending return flush (R1)
        mem[0] = {8'h50, 16'h0};
        mem[128] = {8'h12, 16'h0};
        repeat (2) cycle(1'b1);
        cycle(1'b0);
        cycle(1'b1);
        cycle(1'b0);
        cycle(1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule